// File: doc/BRIEF.md
# Synchronous DRAM Burst Read Sequencer

This block is the device-side read control of a synchronous DRAM. On each rising clock edge it decodes the four active-low command strobes. A mode-load command writes a small runtime configuration: burst length, burst order and data latency. A read command latches a starting column. The block then walks one column per cycle through the burst, requesting each word from an internal array. Every returned word is delayed so that the first word appears on the data output exactly the programmed latency after the command edge, and the rest follow back to back.

The array is expected to return `arr_data` combinationally for `arr_col` while `arr_rd` is high. The sequencer captures that word on the clock edge that ends the beat cycle. Bank activation timing, writes and refresh are handled elsewhere.

Top module: `sdram_burst_rd`

## Requirements
- R1: After reset `dq_valid` and `dq_out` are 0, and the mode is burst length 1, sequential order, latency 3.
- R2: A read command is sel_n=0, row_strobe_n=1, col_strobe_n=0, wr_en_n=1 at a rising edge, and it takes `addr` as the start column. Every other combination, and any cycle with sel_n=1, starts no burst and leaves the mode unchanged.
- R3: A mode-load command is all four strobes low. It takes the burst length code from addr[2:0] (0→1, 1→2, 2→4, 3→8, 7→full page, 4..6→1), the order from addr[3] (0 sequential, 1 interleaved) and the latency code from addr[6:4] (2 gives latency 2, any other value gives 3).
- R4: With latency L, burst word k is on `dq_out` with `dq_valid`=1 in the cycle after rising edge L+k, counted from the edge that sampled the read command (edge 0). `dq_valid` drops after the last word.
- R5: A sequential burst of length N steps the column upward by one and wraps inside the N-aligned block that holds the start column.
- R6: In an interleaved burst, word k uses the start column with its low log2(N) bits XORed with k.
- R7: A full-page burst delivers 256 words from the start column upward and wraps from column 255 to 0. It is always sequential, even when addr[3] was 1 at mode load.
- R8: A read command that arrives during a burst ends the old burst at once. The new burst's words follow the old burst's last issued word with no gap and no extra word.
- R9: Whenever `dq_valid` is 0, `dq_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Device select strobe, active low |
| row_strobe_n | input | 1 | Row strobe, active low |
| col_strobe_n | input | 1 | Column strobe, active low |
| wr_en_n | input | 1 | Write strobe, active low |
| addr | input | COL_W | Start column for reads; mode fields for mode load |
| arr_rd | output | 1 | Array read request for the current beat |
| arr_col | output | COL_W | Column addressed in the current beat |
| arr_data | input | DATA_W | Word returned by the array for `arr_col` |
| dq_valid | output | 1 | Output word valid |
| dq_out | output | DATA_W | Output word |

## Verification
The bench targets the wrap points: a sequential start in the middle of a block of 2 or 4, which a design that did not wrap would carry into the next block. An interleaved start that a plain adder would order wrongly is also covered. A full-page run across column 255 is checked, and a design that did not wrap there would fetch from a different row. Both latency settings are measured to the exact cycle, because an off-by-one pipeline shifts every word. A read is also issued in the middle of a burst: a design that let the old burst finish would show the wrong columns, and one that paused would leave a gap. Write, activate and deselected commands are sent followed by a read under the old mode, so a decoder that took them as commands would start a spurious burst or change the mode.

// File: rtl/sdram_burst_rd.sv
`timescale 1ns/1ps
module sdram_burst_rd #(
  parameter int COL_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              row_strobe_n,
  input  logic              col_strobe_n,
  input  logic              wr_en_n,
  input  logic [COL_W-1:0]  addr,
  output logic              arr_rd,
  output logic [COL_W-1:0]  arr_col,
  input  logic [DATA_W-1:0] arr_data,
  output logic              dq_valid,
  output logic [DATA_W-1:0] dq_out
);
  function automatic logic [COL_W-1:0] len_mask(input logic [2:0] code);
    case (code)
      3'd1:    return COL_W'(1);
      3'd2:    return COL_W'(3);
      3'd3:    return COL_W'(7);
      3'd7:    return '1;
      default: return '0;
    endcase
  endfunction

  wire is_rd   = !sel_n &&  row_strobe_n && !col_strobe_n &&  wr_en_n;
  wire is_mode = !sel_n && !row_strobe_n && !col_strobe_n && !wr_en_n;

  logic [2:0] len_code;
  logic       il_mode;
  logic       lat3;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      len_code <= 3'd0;
      il_mode  <= 1'b0;
      lat3     <= 1'b1;
    end else if (is_mode) begin
      len_code <= addr[2:0];
      il_mode  <= addr[3];
      lat3     <= (addr[6:4] != 3'd2);
    end

  logic             active;
  logic             b_il;
  logic [COL_W-1:0] start, cnt, bmask;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      active <= 1'b0;
      b_il   <= 1'b0;
      start  <= '0;
      cnt    <= '0;
      bmask  <= '0;
    end else if (is_rd) begin
      active <= 1'b1;
      b_il   <= il_mode && (len_code != 3'd7);
      start  <= addr;
      cnt    <= '0;
      bmask  <= len_mask(len_code);
    end else if (active) begin
      if (cnt == bmask) active <= 1'b0;
      else              cnt    <= cnt + 1'b1;
    end

  assign arr_rd  = active;
  assign arr_col = b_il ? (start ^ cnt)
                        : ((start & ~bmask) | ((start + cnt) & bmask));

  logic [2:0]        pv;
  logic [DATA_W-1:0] pd0, pd1, pd2;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pv  <= '0;
      pd0 <= '0;
      pd1 <= '0;
      pd2 <= '0;
    end else begin
      pv  <= {pv[1:0], arr_rd};
      pd0 <= arr_rd ? arr_data : '0;
      pd1 <= pd0;
      pd2 <= pd1;
    end

  assign dq_valid = lat3 ? pv[2] : pv[1];
  assign dq_out   = lat3 ? pd2   : pd1;
endmodule

module sdram_burst_rd_chk #(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             is_rd,
  input logic             is_mode,
  input logic [COL_W-1:0] addr,
  input logic             arr_rd,
  input logic [COL_W-1:0] arr_col,
  input logic [COL_W-1:0] cnt,
  input logic [COL_W-1:0] bmask,
  input logic             b_il,
  input logic [2:0]       len_code,
  input logic             il_mode,
  input logic             lat3,
  input logic             dq_valid
);
  p_start_col_r2: assert property (@(posedge clk) disable iff (!rst_n)
    is_rd |=> (arr_rd && arr_col == $past(addr)));

  p_mode_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !is_mode |=> $stable({len_code, il_mode, lat3}));

  p_lat2_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_rd && !lat3) |-> ##2 dq_valid);

  p_lat3_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_rd && lat3) |-> ##3 dq_valid);

  p_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_rd && cnt == bmask && !is_rd) |=> !arr_rd);

  p_seq_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_rd && $past(arr_rd) && !$past(is_rd) && !b_il) |->
      (((arr_col & ~bmask) == ($past(arr_col) & ~bmask)) &&
       ((arr_col & bmask) == (($past(arr_col) + 1'b1) & bmask))));
endmodule

bind sdram_burst_rd sdram_burst_rd_chk #(.COL_W(COL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .is_rd(is_rd), .is_mode(is_mode), .addr(addr),
  .arr_rd(arr_rd), .arr_col(arr_col), .cnt(cnt), .bmask(bmask), .b_il(b_il),
  .len_code(len_code), .il_mode(il_mode), .lat3(lat3), .dq_valid(dq_valid)
);

// File: tb/sdram_burst_rd_test.sv
`timescale 1ns/1ps
module sdram_burst_rd_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_n = 1'b1, row_strobe_n = 1'b1, col_strobe_n = 1'b1, wr_en_n = 1'b1;
  logic [7:0]  addr = '0;
  logic        arr_rd;
  logic [7:0]  arr_col;
  logic [15:0] arr_data;
  logic        dq_valid;
  logic [15:0] dq_out;
  int total = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;
  assign arr_data = {8'hA5, arr_col};

  sdram_burst_rd #(.COL_W(8), .DATA_W(16)) uut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .row_strobe_n(row_strobe_n),
    .col_strobe_n(col_strobe_n), .wr_en_n(wr_en_n), .addr(addr),
    .arr_rd(arr_rd), .arr_col(arr_col), .arr_data(arr_data),
    .dq_valid(dq_valid), .dq_out(dq_out));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pins(input bit s, input bit r, input bit c, input bit w, input logic [7:0] a);
    sel_n = s; row_strobe_n = r; col_strobe_n = c; wr_en_n = w; addr = a;
  endtask

  task automatic nop();
    pins(0, 1, 1, 1, 8'h00);
  endtask

  function automatic int exp_col(int start, int k, int blen, bit il);
    int base, off;
    if (blen == 256) return (start + k) % 256;
    base = start - start % blen;
    off  = start % blen;
    if (il) return base + (off ^ k);
    return base + (off + k) % blen;
  endfunction

  task automatic check_idle(input string req);
    chk(dq_valid == 1'b0, req, dq_valid, 0);
    chk(dq_out == 16'h0, "R9", dq_out, 0);
  endtask

  task automatic check_word(input string req, input int col);
    chk(dq_valid == 1'b1, req, dq_valid, 1);
    chk(dq_out == (16'hA500 | col), req, dq_out, 16'hA500 | col);
  endtask

  task automatic set_mode(input int code, input bit il, input int latc);
    @(negedge clk);
    pins(0, 0, 0, 0, 8'({latc[2:0], il, code[2:0]}));
    @(negedge clk);
    nop();
  endtask

  task automatic run_read(input int start, input int blen, input bit il,
                          input int lat, input string req);
    @(negedge clk);
    for (int e = 0; e <= lat + blen + 2; e++) begin
      if (e == 0) pins(0, 1, 0, 1, 8'(start));
      else nop();
      @(negedge clk);
      if (e >= lat && e - lat < blen) check_word(req, exp_col(start, e - lat, blen, il));
      else check_idle(req);
    end
  endtask

  task automatic t_reset();
    check_idle("R1");
    run_read('h13, 1, 0, 3, "R1");
  endtask

  task automatic t_seq();
    set_mode(2, 0, 2);
    run_read('h05, 4, 0, 2, "R5");
    set_mode(1, 0, 2);
    run_read('h0F, 2, 0, 2, "R5");
  endtask

  task automatic t_il();
    set_mode(3, 1, 3);
    run_read('h2B, 8, 1, 3, "R6");
    set_mode(2, 1, 2);
    run_read('h76, 4, 1, 2, "R6");
  endtask

  task automatic t_full();
    set_mode(7, 1, 2);
    run_read('hFE, 256, 0, 2, "R7");
  endtask

  task automatic t_codes();
    set_mode(5, 0, 1);
    run_read('h44, 1, 0, 3, "R3");
  endtask

  task automatic t_ignored();
    set_mode(3, 0, 3);
    @(negedge clk);
    for (int e = 0; e < 8; e++) begin
      case (e)
        0: pins(0, 1, 0, 0, 8'h11);
        1: pins(1, 1, 0, 1, 8'h22);
        2: pins(0, 0, 1, 1, 8'h33);
        3: pins(1, 0, 0, 0, 8'h21);
        default: nop();
      endcase
      @(negedge clk);
      check_idle("R2");
    end
    run_read('h9A, 8, 0, 3, "R2");
  endtask

  task automatic t_trunc();
    set_mode(3, 0, 2);
    @(negedge clk);
    for (int e = 0; e <= 15; e++) begin
      if (e == 0)      pins(0, 1, 0, 1, 8'h00);
      else if (e == 3) pins(0, 1, 0, 1, 8'h40);
      else nop();
      @(negedge clk);
      if (e >= 2 && e <= 4)       check_word("R8", e - 2);
      else if (e >= 5 && e <= 12) check_word("R8", 'h40 + e - 5);
      else check_idle("R8");
    end
  endtask

  initial begin
    #(20ns * 200000);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    nop();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_seq();
    t_il();
    t_full();
    t_codes();
    t_ignored();
    t_trunc();
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule